// File: doc/BRIEF.md
# Sum-Signal Slope Trigger

This block watches one 3×3 photosensor sub-module. Each clock it takes nine unsigned 14-bit samples, one per photosensor. It adds them into a single total. It then smooths that total with a moving average whose window is a power of two (1, 2, 4 or 8 clocks).

The block fires a one-clock trigger when the smoothed total has climbed by at least a programmable threshold compared with its own value a programmable number of clocks earlier. The test looks at the slope of the smoothed total, not at its level, so a slowly drifting baseline does not fire it.

A hold-off counter stops a single pulse from producing several triggers. A priming counter keeps the trigger quiet until the history is full again after a reset or after any change to the smoothing, look-back or threshold settings. The smoothed total is also brought out so it can be monitored. The usual operating point is a look-back of 10 to 99 clocks, a threshold that is a multiple of 9 ADC units between 9 and 270, and a hold-off of 100 clocks.

Top module: `slope_trigger`

## Requirements
- R1: While `rst_n` is low, `trig` is 0 and `smooth_sum` is 0, whatever the channel inputs carry.
- R2: Let X(k) be the total of the nine channel samples taken at clock edge k. Channel c occupies bits [14c+13:14c] of `ch_samples`, and totals from before reset release count as 0. With `cfg_exp` = 0, `smooth_sum` after edge k equals X(k-2).
- R3: With `cfg_exp` = N, `smooth_sum` after edge k equals floor((X(k-1-2^N) + … + X(k-2)) / 2^N). That is the mean of the 2^N most recent totals, with a two-clock latency.
- R4: `cfg_exp` may change on any clock. The value after the change already averages the full new window of past totals, with no refill period.
- R5: Let S(k) be `smooth_sum` after edge k, with S = 0 before reset release. Let L be `cfg_lookback`, with 0 treated as 1. When priming and hold-off allow it, `trig` is 1 after edge k exactly when S(k-1) − S(k-1-L) ≥ `cfg_thresh`. A rise equal to the threshold fires; a rise one below it does not.
- R6: The difference is signed, so a falling smoothed total never fires, whatever the size of the fall.
- R7: After `trig` is 1 following edge k, it stays 0 after edges k+1 through k+max(H,1), where H is `cfg_holdoff`.
- R8: After reset release, `trig` can first be 1 after edge L+11, counting the first edge after release as edge 1.
- R9: If `cfg_exp`, `cfg_lookback` or `cfg_thresh` at edge c differs from its value at edge c-1, `trig` stays 0 after edges c through c+L+10. A change of `cfg_holdoff` does not restart priming.
- R10: With all nine channels at full scale (16383) and any window, `smooth_sum` settles at 147447 with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one new sample per channel per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_samples | input | 126 | Nine unsigned 14-bit samples, channel c at bits [14c+13:14c] |
| cfg_exp | input | 2 | Smoothing exponent N, window of 2^N clocks |
| cfg_lookback | input | 7 | Look-back distance L in clocks (0 treated as 1) |
| cfg_thresh | input | 9 | Minimum rise of the smoothed total that fires, in ADC units |
| cfg_holdoff | input | 8 | Clocks of trigger blocking after a trigger (0 treated as 1) |
| trig | output | 1 | One-clock trigger pulse |
| smooth_sum | output | 18 | Smoothed channel total for monitoring |

## Verification
The hardest conditions to reach are the edges of the priming window. A qualifying rise must be present while the history is still being refilled, and it must end exactly one clock before priming completes, or still be true on the very first primed clock. The stimulus reaches both cases with a reset followed by a step in one channel, timed so that the rise window closes at edge 20 in one run and reaches edge 21 in the next. A second run combines a configuration change with a step on the same clock. The threshold boundary is reached with a 4-clock smoothing window and channel steps of exactly the threshold and one below it, so the smoothed rise reaches those values only once the window has filled.

// File: rtl/slope_trig_pkg.sv
package slope_trig_pkg;

    // Field widths of the run-time settings.
    localparam int CFG_EXP_W = 2;   // smoothing exponent, 0..3
    localparam int CFG_LB_W  = 7;   // look-back distance in clocks
    localparam int CFG_TH_W  = 9;   // rise threshold in ADC units
    localparam int CFG_HO_W  = 8;   // hold-off length in clocks

    // Settings whose change invalidates the stored history.
    typedef struct packed {
        logic [CFG_EXP_W-1:0] exp;
        logic [CFG_LB_W-1:0]  lookback;
        logic [CFG_TH_W-1:0]  thresh;
    } trig_cfg_t;

endpackage

// File: rtl/st_channel_sum.sv
module st_channel_sum #(
    parameter int NCH      = 9,
    parameter int SAMPLE_W = 14,
    parameter int SUM_W    = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH*SAMPLE_W-1:0]   samples_i,
    output logic [SUM_W-1:0]          total_o
);

    localparam longint SUM_MAX = longint'(NCH) * ((longint'(1) << SAMPLE_W) - 1);

    typedef struct packed {
        logic [SUM_W-1:0] total;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.total = '0;
        for (int c = 0; c < NCH; c++) begin
            st_d.total = st_d.total + SUM_W'(samples_i[c*SAMPLE_W +: SAMPLE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total_o = st_q.total;

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.total <= SUM_W'(SUM_MAX)); // R2

endmodule

// File: rtl/st_window_avg.sv
module st_window_avg #(
    parameter int NCH      = 9,
    parameter int SAMPLE_W = 14,
    parameter int SUM_W    = 18,
    parameter int EXP_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUM_W-1:0]  total_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [SUM_W-1:0]  avg_o
);

    localparam int     MAX_EXP = (1 << EXP_W) - 1;
    localparam int     DEPTH   = 1 << MAX_EXP;
    localparam int     ACC_W   = SUM_W + MAX_EXP;
    localparam longint SUM_MAX = longint'(NCH) * ((longint'(1) << SAMPLE_W) - 1);
    localparam longint ACC_MAX = longint'(DEPTH) * SUM_MAX;

    // One running sum per selectable window, all kept current so that the
    // exponent may change without a refill period.
    typedef struct packed {
        logic [DEPTH-1:0][SUM_W-1:0]   tap;
        logic [MAX_EXP:0][ACC_W-1:0]   acc;
        logic [SUM_W-1:0]              avg;
    } avg_st_t;

    avg_st_t          st_d, st_q;
    logic [ACC_W-1:0] sel_acc;

    always_comb begin
        st_d       = st_q;
        st_d.tap[0] = total_i;
        for (int j = 1; j < DEPTH; j++) begin
            st_d.tap[j] = st_q.tap[j-1];
        end
        for (int k = 0; k <= MAX_EXP; k++) begin
            st_d.acc[k] = st_q.acc[k] + ACC_W'(total_i) - ACC_W'(st_q.tap[(1 << k) - 1]);
        end
        sel_acc  = st_q.acc[exp_i];
        st_d.avg = SUM_W'(sel_acc >> exp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_o = st_q.avg;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc[MAX_EXP] <= ACC_W'(ACC_MAX)); // R10

    AST_AVG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.avg <= SUM_W'(SUM_MAX)); // R3

endmodule

// File: rtl/st_slope_detect.sv
module st_slope_detect
    import slope_trig_pkg::*;
#(
    parameter int SUM_W      = 18,
    parameter int WINDOW_MAX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SUM_W-1:0]     avg_i,
    input  trig_cfg_t            cfg_i,
    input  logic [CFG_HO_W-1:0]  holdoff_i,
    output logic                 trig_o
);

    localparam int LB_MAX   = 1 << CFG_LB_W;
    localparam int PRIME_ADD = WINDOW_MAX + 2;
    localparam int WARM_TOP = LB_MAX + PRIME_ADD;
    localparam int WARM_W   = $clog2(WARM_TOP + 1);

    typedef struct packed {
        logic [LB_MAX-1:0][SUM_W-1:0] hist;
        trig_cfg_t                    cfg;
        logic                         seen;
        logic [WARM_W-1:0]            warm;
        logic [CFG_HO_W-1:0]          hold;
        logic                         trig;
    } det_st_t;

    det_st_t              st_d, st_q;
    logic [CFG_LB_W:0]    lb_eff;
    logic [CFG_LB_W-1:0]  tap_idx;
    logic [SUM_W-1:0]     old;
    logic signed [SUM_W:0] diff;
    logic                 rising;
    logic                 changed;
    logic                 primed;
    logic                 fire;

    always_comb begin
        st_d    = st_q;
        lb_eff  = (cfg_i.lookback == '0) ? (CFG_LB_W+1)'(1) : {1'b0, cfg_i.lookback};
        tap_idx = CFG_LB_W'(lb_eff - 1'b1);
        old     = st_q.hist[tap_idx];
        diff    = $signed({1'b0, avg_i}) - $signed({1'b0, old});
        rising  = diff >= $signed({{(SUM_W+1-CFG_TH_W){1'b0}}, cfg_i.thresh});
        changed = st_q.seen && (cfg_i != st_q.cfg);
        primed  = int'(st_q.warm) >= int'(lb_eff) + PRIME_ADD;
        fire    = rising && !changed && primed && (st_q.hold == '0);

        st_d.hist[0] = avg_i;
        for (int j = 1; j < LB_MAX; j++) begin
            st_d.hist[j] = st_q.hist[j-1];
        end
        st_d.cfg  = cfg_i;
        st_d.seen = 1'b1;
        if (changed)                               st_d.warm = '0;
        else if (st_q.warm != WARM_W'(WARM_TOP))   st_d.warm = st_q.warm + 1'b1;
        if (fire)                                  st_d.hold = (holdoff_i == '0) ? CFG_HO_W'(1) : holdoff_i;
        else if (st_q.hold != '0)                  st_d.hold = st_q.hold - 1'b1;
        st_d.trig = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o = st_q.trig;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trig |=> !st_q.trig); // R7

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold != '0) |=> !st_q.trig); // R7

    AST_COLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == '0) |=> !st_q.trig); // R8

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trig && ($past(cfg_i.thresh) != '0)) |-> ($past(avg_i) > $past(old))); // R6

endmodule

// File: rtl/slope_trigger.sv
module slope_trigger
    import slope_trig_pkg::*;
#(
    parameter int NCH      = 9,
    parameter int SAMPLE_W = 14,
    localparam int SUM_W   = SAMPLE_W + $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH*SAMPLE_W-1:0]  ch_samples,
    input  logic [CFG_EXP_W-1:0]     cfg_exp,
    input  logic [CFG_LB_W-1:0]      cfg_lookback,
    input  logic [CFG_TH_W-1:0]      cfg_thresh,
    input  logic [CFG_HO_W-1:0]      cfg_holdoff,
    output logic                     trig,
    output logic [SUM_W-1:0]         smooth_sum
);

    localparam int WINDOW_MAX = 1 << ((1 << CFG_EXP_W) - 1);

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] avg;
    trig_cfg_t        cfg_now;

    assign cfg_now.exp      = cfg_exp;
    assign cfg_now.lookback = cfg_lookback;
    assign cfg_now.thresh   = cfg_thresh;

    st_channel_sum #(
        .NCH      (NCH),
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .samples_i (ch_samples),
        .total_o   (total)
    );

    st_window_avg #(
        .NCH      (NCH),
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W),
        .EXP_W    (CFG_EXP_W)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .total_i (total),
        .exp_i   (cfg_exp),
        .avg_o   (avg)
    );

    st_slope_detect #(
        .SUM_W      (SUM_W),
        .WINDOW_MAX (WINDOW_MAX)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_i     (avg),
        .cfg_i     (cfg_now),
        .holdoff_i (cfg_holdoff),
        .trig_o    (trig)
    );

    assign smooth_sum = avg;

endmodule

// File: tb/slope_trigger_tb_top.sv
module slope_trigger_tb_top;

    localparam int NCH = 9;
    localparam int SW  = 14;
    localparam int AW  = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*SW-1:0] ch_bus = '0;
    logic [1:0]        c_exp = '0;
    logic [6:0]        c_lb = 7'd10;
    logic [8:0]        c_th = 9'd511;
    logic [7:0]        c_ho = 8'd100;
    logic              trig;
    logic [AW-1:0]     smooth;

    always #5 clk = ~clk;

    slope_trigger dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_samples   (ch_bus),
        .cfg_exp      (c_exp),
        .cfg_lookback (c_lb),
        .cfg_thresh   (c_th),
        .cfg_holdoff  (c_ho),
        .trig         (trig),
        .smooth_sum   (smooth)
    );

    typedef struct {
        int    s;
        bit    t;
        string ts;
        string tt;
    } exp_item_t;

    exp_item_t sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    chv[NCH];
    int    xs[0:8191];
    int    ss[0:8191];
    int    idx = 0;
    int    wq = 0;
    int    hq = 0;
    int    pe = 0;
    int    pl = 0;
    int    pt = 0;
    string tag_s = "R2";
    string tag_t = "R5";

    task automatic check(string tag, int act, int expv, string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: applies one clock of samples, predicts outputs after the next edge.
    task automatic step();
        int        sum;
        int        acc;
        int        span;
        int        c1;
        int        sold;
        bit        chg;
        bit        cond;
        bit        fire;
        exp_item_t it;
        sum = 0;
        acc = 0;
        for (int c = 0; c < NCH; c++) begin
            ch_bus[c*SW +: SW] = chv[c][SW-1:0];
            sum += chv[c];
        end
        idx++;
        xs[idx] = sum;
        span = 1 << c_exp;
        for (int m = idx - 1 - span; m <= idx - 2; m++) if (m >= 1) acc += xs[m];
        ss[idx] = acc >> c_exp;
        c1   = (c_lb == 0) ? 1 : int'(c_lb);
        chg  = (idx >= 2) && (int'(c_exp) != pe || int'(c_lb) != pl || int'(c_th) != pt);
        sold = (idx - 1 - c1 >= 1) ? ss[idx-1-c1] : 0;
        cond = (ss[idx-1] - sold) >= int'(c_th);
        fire = cond && !chg && (wq >= c1 + 10) && (hq == 0);
        hq   = fire ? ((c_ho == 0) ? 1 : int'(c_ho)) : ((hq > 0) ? hq - 1 : 0);
        wq   = chg ? 0 : ((wq < 138) ? wq + 1 : 138);
        pe = int'(c_exp);
        pl = int'(c_lb);
        pt = int'(c_th);
        it.s  = ss[idx];
        it.t  = fire;
        it.ts = tag_s;
        it.tt = tag_t;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic set_all(int v);
        for (int c = 0; c < NCH; c++) chv[c] = v;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic do_reset();
        wait (sbq.size() == 0);
        rst_n = 1'b0;
        for (int c = 0; c < NCH; c++) ch_bus[c*SW +: SW] = 14'd5000;
        repeat (3) @(negedge clk);
        check("R1", int'(trig), 0, "trig in reset");
        check("R1", int'(smooth), 0, "smooth_sum in reset");
        idx = 0; xs[0] = 0; ss[0] = 0; wq = 0; hq = 0;
        rst_n = 1'b1;
    endtask

    // Monitor: compares each edge's outputs against the predicted item.
    initial begin : mon
        exp_item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sbq.size() > 0) begin
                it = sbq.pop_front();
                check(it.ts, int'(smooth), it.s, "smooth_sum");
                check(it.tt, int'(trig), int'(it.t), "trig");
            end
        end
    end

    initial begin : watchdog
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : drv
        do_reset();

        // R2: plain total, rising ramps per channel
        c_exp = 0; c_lb = 10; c_th = 511; c_ho = 100;
        tag_s = "R2"; tag_t = "R5";
        for (int t = 0; t < 60; t++) begin
            for (int c = 0; c < NCH; c++) chv[c] = (c * 1111 + t * 53) % 16384;
            step();
        end

        // R3, R4: every window, then live exponent switching
        tag_s = "R3 R4"; tag_t = "R9";
        for (int e = 1; e < 4; e++) begin
            c_exp = 2'(e);
            for (int t = 0; t < 50; t++) begin
                for (int c = 0; c < NCH; c++) chv[c] = (t * t * 7 + c * 401 + e * 333) % 16384;
                step();
            end
        end
        for (int t = 0; t < 40; t++) begin
            c_exp = ((t / 5) % 2 == 0) ? 2'd0 : 2'd3;
            for (int c = 0; c < NCH; c++) chv[c] = (t * 977 + c * 211) % 16384;
            step();
        end

        // R5, R6: threshold boundary through a 4-clock window
        do_reset();
        c_exp = 2; c_lb = 10; c_th = 90; c_ho = 100;
        tag_s = "R3"; tag_t = "R5";
        set_all(100); steps(40);
        chv[0] = 190; steps(150);
        tag_t = "R6"; chv[0] = 100; steps(60);
        tag_t = "R5"; chv[0] = 189; steps(60);
        tag_t = "R6"; chv[0] = 100; steps(60);
        tag_t = "R5"; chv[0] = 190; steps(40);

        // R7: staircase against a short and a zero hold-off
        tag_s = "R2"; tag_t = "R7";
        c_exp = 0; c_ho = 3;
        for (int t = 0; t < 60; t++) begin chv[0] = 100 + t * 200; step(); end
        c_ho = 0;
        for (int t = 0; t < 30; t++) begin chv[1] = 100 + t * 200; step(); end

        // R8: rise window ends at edge 20, then reaches edge 21
        do_reset();
        c_exp = 0; c_lb = 10; c_th = 90; c_ho = 100;
        tag_t = "R8";
        set_all(100); steps(7);
        chv[0] = 1000; steps(33);
        do_reset();
        set_all(100); steps(8);
        chv[0] = 1000; steps(40);

        // R9: configuration change together with a step, then a later step
        steps(150);
        tag_t = "R9";
        c_th = 99; chv[0] = 1200; steps(40);
        chv[0] = 1500; steps(40);

        // R10: full scale, widest window
        tag_s = "R10";
        c_exp = 3; set_all(16383); steps(30);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule